// File: doc/BRIEF.md
# Move Destination Write Decoder

This block is the write half of a register-to-register move in a small 16-bit processor core. Each cycle that a move is presented, it takes a 7-bit destination code, a source value and a flag that says whether the source is one byte or a full word. It turns the code into one register update or one data-memory write request. When a pointer-indirect destination is chosen, it also performs the matching pointer step. Instruction fetch, source selection, flags and the data memory itself sit outside the block.

The block holds the state that destination codes can name: a bank of accumulators plus an accumulator pointer, a stack pointer, two data pointers, a frame base with an 8-bit offset, a general register with byte views, two loop counters, and a one-shot prefix holder. Writing the prefix holder affects only the next move. For that move it supplies the high byte when a byte source is widened, and it switches a few codes into a second register space. The data-memory request is registered and appears one cycle after the move. It carries the address, the data and a byte/word mode bit.

Top module: `mdw_top`

## Requirements
- R1: A word source into a 16-bit destination is stored unchanged. A byte destination (accumulator pointer, offset, general-register low or high byte, prefix holder) takes bits [7:0] of the source and ignores bits [15:8].
- R2: A byte source (`mv_src_wide`=0) written to a 16-bit destination gets high byte 00h. When the prefix is active, it gets the held prefix byte as its high byte instead.
- R3: Code 111_0110 performs no register or memory write. Every code this block does not assign (for example 010_1101, 100_1110, x_0xxx) behaves the same way.
- R4: Code nnn_1001 writes accumulator nnn, or accumulator 8+nnn when the prefix is active. Code 000_1010 writes the accumulator selected by the accumulator pointer. Code 000_1000 (unprefixed) loads the accumulator pointer from source bits [3:0].
- R5: Code 000_1101 first adds one to the stack pointer (modulo 65536) and then issues a word write of the widened source at the new stack pointer. Code 001_1101 loads the stack pointer. Codes 110_1101 and 111_1101 load loop counter 0 and loop counter 1.
- R6: For data pointer n (code bit 6), suffix bits [5:4] select the action: 00 writes memory at the pointer with no change, 01 increments the pointer first, 10 decrements it first, and 11 loads the pointer. All pointer arithmetic is modulo 65536.
- R7: Codes 000_1110, 001_1110 and 010_1110 write memory at base + zero-extended offset. They leave the offset unchanged, increment it first, or decrement it first (modulo 256). Code 011_1110 loads the offset and 111_1110 loads the base.
- R8: Code 101_1110 loads the whole general register and 110_1110 loads only its low byte. With the prefix active, 001_1110 loads only its high byte, and any xxx_1000 code writes nothing.
- R9: Code nnn_1011 sets the prefix active and holds source bits [7:0], whatever nnn is. Any other move clears the prefix after it has been used once.
- R10: A memory write request (`mem_we`=1) appears in the cycle after the move, with the post-update address. Stack pushes are always word mode (`mem_word`=1). Other memory destinations are word mode when the source is a word or the prefix is active. In byte mode the data is {00h, source[7:0]}.
- R11: After synchronous reset every register is zero, the prefix is inactive and no memory request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mv_valid | input | 1 | A move is presented this cycle |
| mv_dst | input | 7 | Destination code |
| mv_src | input | 16 | Source value |
| mv_src_wide | input | 1 | 1: word source, 0: byte source |
| acc_rd_idx | input | 4 | Accumulator observation select |
| acc_rd_data | output | 16 | Selected accumulator |
| obs_ap | output | 4 | Accumulator pointer |
| obs_sp | output | 16 | Stack pointer |
| obs_bp | output | 16 | Frame base |
| obs_offs | output | 8 | Frame offset |
| obs_dp0 | output | 16 | Data pointer 0 |
| obs_dp1 | output | 16 | Data pointer 1 |
| obs_gr | output | 16 | General register |
| obs_lc0 | output | 16 | Loop counter 0 |
| obs_lc1 | output | 16 | Loop counter 1 |
| pfx_active | output | 1 | Prefix applies to the next move |
| mem_we | output | 1 | Data-memory write request |
| mem_word | output | 1 | 1: word write, 0: byte write |
| mem_addr | output | 16 | Write address |
| mem_wdata | output | 16 | Write data |

## Verification
The assertions assume that `mv_dst`, `mv_src` and `mv_src_wide` hold known values whenever `mv_valid` is high, and that reset is held for at least one edge before the first move. The bench changes inputs only on the falling edge and lowers `mv_valid` while it observes state. It also makes prefix moves directly before the moves they modify, so that each prefix use stays within the one-move window.

// File: rtl/mdw_pkg.sv
package mdw_pkg;
    localparam int DW  = 16;
    localparam int BW  = 8;
    localparam int AW  = 16;
    localparam int NDP = 2;
    localparam int NLC = 2;

    typedef enum logic [3:0] {
        K_NULL, K_AP, K_ACCN, K_ACCA, K_PFX, K_PUSH, K_SP, K_LC,
        K_BPM, K_OFFS, K_GR, K_GRL, K_GRH, K_BP, K_DPM, K_DP
    } kind_e;

    typedef enum logic [1:0] { ST_NONE, ST_INC, ST_DEC } step_e;

    typedef struct packed {
        kind_e       kind;
        logic [3:0]  idx;
        step_e       step;
    } dec_t;

    function automatic step_e step_of(input logic [1:0] s);
        case (s)
            2'd1:    return ST_INC;
            2'd2:    return ST_DEC;
            default: return ST_NONE;
        endcase
    endfunction

    function automatic dec_t decode_dst(input logic [6:0] c, input logic pfx);
        dec_t       d;
        logic [2:0] hi;
        hi     = c[6:4];
        d.kind = K_NULL;
        d.idx  = '0;
        d.step = ST_NONE;
        case (c[3:0])
            4'h8: if (!pfx && hi == 3'd0) d.kind = K_AP;
            4'h9: begin d.kind = K_ACCN; d.idx = {pfx, hi}; end
            4'hA: if (hi == 3'd0) d.kind = K_ACCA;
            4'hB: d.kind = K_PFX;
            4'hD: begin
                case (hi)
                    3'd0:       d.kind = K_PUSH;
                    3'd1:       d.kind = K_SP;
                    3'd6, 3'd7: begin d.kind = K_LC; d.idx = {3'b000, hi[0]}; end
                    default:    d.kind = K_NULL;
                endcase
            end
            4'hE: begin
                if (pfx && hi == 3'd1) d.kind = K_GRH;
                else begin
                    case (hi)
                        3'd0, 3'd1, 3'd2: begin d.kind = K_BPM; d.step = step_of(hi[1:0]); end
                        3'd3:    d.kind = K_OFFS;
                        3'd5:    d.kind = K_GR;
                        3'd6:    d.kind = K_GRL;
                        3'd7:    d.kind = K_BP;
                        default: d.kind = K_NULL;
                    endcase
                end
            end
            4'hF: begin
                d.idx = {3'b000, hi[2]};
                if (hi[1:0] == 2'd3) d.kind = K_DP;
                else begin d.kind = K_DPM; d.step = step_of(hi[1:0]); end
            end
            default: d.kind = K_NULL;
        endcase
        return d;
    endfunction
endpackage

// File: rtl/mdw_decode.sv
module mdw_decode
    import mdw_pkg::*;
(
    input  logic [6:0]    code,
    input  logic          pfx_act,
    input  logic [BW-1:0] pfx_byte,
    input  logic [DW-1:0] src,
    input  logic          src_wide,
    output dec_t          dec,
    output logic [DW-1:0] wval,
    output logic [BW-1:0] bval
);
    always_comb begin
        dec  = decode_dst(code, pfx_act);
        bval = src[BW-1:0];
        if (src_wide)     wval = src;
        else if (pfx_act) wval = {pfx_byte, src[BW-1:0]};
        else              wval = {{(DW-BW){1'b0}}, src[BW-1:0]};
    end
endmodule

// File: rtl/mdw_ptrs.sv
module mdw_ptrs
    import mdw_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          valid,
    input  dec_t          dec,
    input  logic [DW-1:0] wval,
    input  logic [BW-1:0] bval,
    output logic [AW-1:0] sp_q,
    output logic [AW-1:0] bp_q,
    output logic [BW-1:0] offs_q,
    output logic [AW-1:0] dp_q [NDP],
    output logic [AW-1:0] addr_n
);
    logic [AW-1:0] sp_n, bp_n;
    logic [BW-1:0] offs_n;
    logic [AW-1:0] dp_n [NDP];

    always_comb begin
        sp_n   = sp_q;
        bp_n   = bp_q;
        offs_n = offs_q;
        for (int i = 0; i < NDP; i++) dp_n[i] = dp_q[i];
        if (valid) begin
            case (dec.kind)
                K_PUSH: sp_n = sp_q + AW'(1);
                K_SP:   sp_n = wval;
                K_BP:   bp_n = wval;
                K_OFFS: offs_n = bval;
                K_BPM: begin
                    if (dec.step == ST_INC)      offs_n = offs_q + BW'(1);
                    else if (dec.step == ST_DEC) offs_n = offs_q - BW'(1);
                end
                K_DP: dp_n[dec.idx[0]] = wval;
                K_DPM: begin
                    if (dec.step == ST_INC)      dp_n[dec.idx[0]] = dp_q[dec.idx[0]] + AW'(1);
                    else if (dec.step == ST_DEC) dp_n[dec.idx[0]] = dp_q[dec.idx[0]] - AW'(1);
                end
                default: ;
            endcase
        end
        case (dec.kind)
            K_PUSH:  addr_n = sp_n;
            K_BPM:   addr_n = bp_n + {{(AW-BW){1'b0}}, offs_n};
            K_DPM:   addr_n = dp_n[dec.idx[0]];
            default: addr_n = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_q   <= '0;
            bp_q   <= '0;
            offs_q <= '0;
        end else begin
            sp_q   <= sp_n;
            bp_q   <= bp_n;
            offs_q <= offs_n;
        end
    end

    for (genvar g = 0; g < NDP; g++) begin : g_dp
        always_ff @(posedge clk) begin
            if (rst) dp_q[g] <= '0;
            else     dp_q[g] <= dp_n[g];
        end
    end

    p_offs_inc_r7: assert property (@(posedge clk) disable iff (rst)
        (valid && dec.kind == K_BPM && dec.step == ST_INC) |=> (offs_q == $past(offs_q) + BW'(1)));

    p_dp_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (valid && dec.kind == K_DPM && dec.step == ST_NONE) |=> ($stable(dp_q[0]) && $stable(dp_q[1])));
endmodule

// File: rtl/mdw_regs.sv
module mdw_regs
    import mdw_pkg::*;
#(
    parameter int ACC_NUM = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       valid,
    input  dec_t                       dec,
    input  logic [DW-1:0]              wval,
    input  logic [BW-1:0]              bval,
    input  logic [$clog2(ACC_NUM)-1:0] rd_idx,
    output logic [DW-1:0]              rd_data,
    output logic [$clog2(ACC_NUM)-1:0] ap_q,
    output logic [DW-1:0]              gr_q,
    output logic [DW-1:0]              lc_q [NLC],
    output logic                       pfx_act,
    output logic [BW-1:0]              pfx_byte
);
    localparam int IW = $clog2(ACC_NUM);

    logic [DW-1:0] acc_q [ACC_NUM];
    logic [3:0]    tgt;
    logic          acc_we;

    assign tgt     = (dec.kind == K_ACCA) ? 4'(ap_q) : dec.idx;
    assign acc_we  = valid && (dec.kind == K_ACCN || dec.kind == K_ACCA);
    assign rd_data = acc_q[rd_idx];

    for (genvar g = 0; g < ACC_NUM; g++) begin : g_acc
        always_ff @(posedge clk) begin
            if (rst)                          acc_q[g] <= '0;
            else if (acc_we && tgt == 4'(g))  acc_q[g] <= wval;
        end
    end

    for (genvar g = 0; g < NLC; g++) begin : g_lc
        always_ff @(posedge clk) begin
            if (rst) lc_q[g] <= '0;
            else if (valid && dec.kind == K_LC && dec.idx[0] == 1'(g)) lc_q[g] <= wval;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ap_q     <= '0;
            gr_q     <= '0;
            pfx_act  <= 1'b0;
            pfx_byte <= '0;
        end else if (valid) begin
            pfx_act <= (dec.kind == K_PFX);
            case (dec.kind)
                K_AP:    ap_q <= bval[IW-1:0];
                K_GR:    gr_q <= wval;
                K_GRL:   gr_q[BW-1:0] <= bval;
                K_GRH:   gr_q[DW-1:BW] <= bval;
                K_PFX:   pfx_byte <= bval;
                default: ;
            endcase
        end
    end

    p_pfx_once_r9: assert property (@(posedge clk) disable iff (rst)
        (valid && dec.kind != K_PFX) |=> !pfx_act);

    p_ap_load_r4: assert property (@(posedge clk) disable iff (rst)
        (valid && dec.kind == K_AP) |=> (ap_q == $past(bval[IW-1:0])));
endmodule

// File: rtl/mdw_top.sv
module mdw_top
    import mdw_pkg::*;
#(
    parameter int ACC_NUM = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       mv_valid,
    input  logic [6:0]                 mv_dst,
    input  logic [15:0]                mv_src,
    input  logic                       mv_src_wide,
    input  logic [$clog2(ACC_NUM)-1:0] acc_rd_idx,
    output logic [15:0]                acc_rd_data,
    output logic [$clog2(ACC_NUM)-1:0] obs_ap,
    output logic [15:0]                obs_sp,
    output logic [15:0]                obs_bp,
    output logic [7:0]                 obs_offs,
    output logic [15:0]                obs_dp0,
    output logic [15:0]                obs_dp1,
    output logic [15:0]                obs_gr,
    output logic [15:0]                obs_lc0,
    output logic [15:0]                obs_lc1,
    output logic                       pfx_active,
    output logic                       mem_we,
    output logic                       mem_word,
    output logic [15:0]                mem_addr,
    output logic [15:0]                mem_wdata
);
    dec_t          dec;
    logic [DW-1:0] wval;
    logic [BW-1:0] bval;
    logic [BW-1:0] pfx_byte;
    logic [AW-1:0] addr_n;
    logic [AW-1:0] dp_q [NDP];
    logic [DW-1:0] lc_q [NLC];
    logic          is_mem, word_n;

    mdw_decode u_dec (
        .code(mv_dst), .pfx_act(pfx_active), .pfx_byte(pfx_byte),
        .src(mv_src), .src_wide(mv_src_wide),
        .dec(dec), .wval(wval), .bval(bval)
    );

    mdw_ptrs u_ptrs (
        .clk(clk), .rst(rst), .valid(mv_valid), .dec(dec), .wval(wval), .bval(bval),
        .sp_q(obs_sp), .bp_q(obs_bp), .offs_q(obs_offs), .dp_q(dp_q), .addr_n(addr_n)
    );

    mdw_regs #(.ACC_NUM(ACC_NUM)) u_regs (
        .clk(clk), .rst(rst), .valid(mv_valid), .dec(dec), .wval(wval), .bval(bval),
        .rd_idx(acc_rd_idx), .rd_data(acc_rd_data), .ap_q(obs_ap), .gr_q(obs_gr),
        .lc_q(lc_q), .pfx_act(pfx_active), .pfx_byte(pfx_byte)
    );

    assign obs_dp0 = dp_q[0];
    assign obs_dp1 = dp_q[1];
    assign obs_lc0 = lc_q[0];
    assign obs_lc1 = lc_q[1];

    assign is_mem = (dec.kind == K_PUSH) || (dec.kind == K_BPM) || (dec.kind == K_DPM);
    assign word_n = (dec.kind == K_PUSH) || mv_src_wide || pfx_active;

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_we    <= 1'b0;
            mem_word  <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else begin
            mem_we    <= mv_valid && is_mem;
            mem_word  <= word_n;
            mem_addr  <= addr_n;
            mem_wdata <= word_n ? wval : {{(DW-BW){1'b0}}, bval};
        end
    end

    p_null_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        (mv_valid && dec.kind == K_NULL) |=> !mem_we);

    p_push_addr_r5: assert property (@(posedge clk) disable iff (rst)
        (mv_valid && dec.kind == K_PUSH) |=> (mem_we && mem_word && mem_addr == obs_sp));

    p_byte_mode_r10: assert property (@(posedge clk) disable iff (rst)
        (mv_valid && dec.kind == K_DPM && !mv_src_wide && !pfx_active)
            |=> (!mem_word && mem_wdata[15:8] == 8'h00));
endmodule

// File: tb/mdw_top_tb.sv
`timescale 1ns/1ps
module mdw_top_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mv_valid = 1'b0;
    logic [6:0]  mv_dst = '0;
    logic [15:0] mv_src = '0;
    logic        mv_src_wide = 1'b0;
    logic [3:0]  acc_rd_idx = '0;
    logic [15:0] acc_rd_data;
    logic [3:0]  obs_ap;
    logic [15:0] obs_sp, obs_bp, obs_dp0, obs_dp1, obs_gr, obs_lc0, obs_lc1;
    logic [7:0]  obs_offs;
    logic        pfx_active, mem_we, mem_word;
    logic [15:0] mem_addr, mem_wdata;

    always #2 clk = ~clk;

    mdw_top u_dut (
        .clk(clk), .rst(rst), .mv_valid(mv_valid), .mv_dst(mv_dst), .mv_src(mv_src),
        .mv_src_wide(mv_src_wide), .acc_rd_idx(acc_rd_idx), .acc_rd_data(acc_rd_data),
        .obs_ap(obs_ap), .obs_sp(obs_sp), .obs_bp(obs_bp), .obs_offs(obs_offs),
        .obs_dp0(obs_dp0), .obs_dp1(obs_dp1), .obs_gr(obs_gr), .obs_lc0(obs_lc0),
        .obs_lc1(obs_lc1), .pfx_active(pfx_active), .mem_we(mem_we), .mem_word(mem_word),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    typedef struct {
        logic        we;
        logic        word;
        logic [15:0] addr;
        logic [15:0] data;
        string       tag;
    } exp_t;

    exp_t q[$];
    exp_t got;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    // reference model state
    logic [15:0] m_acc [16];
    logic [3:0]  m_ap;
    logic [15:0] m_sp, m_bp, m_gr;
    logic [15:0] m_dp [2];
    logic [15:0] m_lc [2];
    logic [7:0]  m_offs, m_pfb;
    logic        m_pf;

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic memx(inout exp_t e, input logic [15:0] a, input logic [15:0] wv,
                        input logic [7:0] b, input logic wide, input logic p);
        e.we   = 1'b1;
        e.addr = a;
        e.word = wide | p;
        e.data = e.word ? wv : {8'h00, b};
    endtask

    task automatic mv(input logic [6:0] c, input logic [15:0] s, input logic w, input string tag);
        exp_t        e;
        logic [15:0] wv;
        logic [7:0]  b;
        logic        p;
        p  = m_pf;
        b  = s[7:0];
        wv = w ? s : {(p ? m_pfb : 8'h00), b};
        e.we = 1'b0; e.word = 1'b0; e.addr = '0; e.data = '0; e.tag = tag;
        m_pf = 1'b0;
        if (c[3:0] == 4'hB) begin m_pf = 1'b1; m_pfb = b; end
        else if (c[3:0] == 4'h9) m_acc[{p, c[6:4]}] = wv;
        else if (p && c[3:0] == 4'h8) begin end
        else if (p && c == 7'h1E) m_gr[15:8] = b;
        else if (c[3:0] == 4'hF) begin
            case (c[5:4])
                2'd3: m_dp[c[6]] = wv;
                default: begin
                    if (c[5:4] == 2'd1) m_dp[c[6]] = m_dp[c[6]] + 16'd1;
                    if (c[5:4] == 2'd2) m_dp[c[6]] = m_dp[c[6]] - 16'd1;
                    memx(e, m_dp[c[6]], wv, b, w, p);
                end
            endcase
        end else begin
            case (c)
                7'h08: m_ap = b[3:0];
                7'h0A: m_acc[m_ap] = wv;
                7'h0D: begin
                    m_sp = m_sp + 16'd1;
                    e.we = 1'b1; e.word = 1'b1; e.addr = m_sp; e.data = wv;
                end
                7'h1D: m_sp = wv;
                7'h6D: m_lc[0] = wv;
                7'h7D: m_lc[1] = wv;
                7'h0E, 7'h1E, 7'h2E: begin
                    if (c == 7'h1E) m_offs = m_offs + 8'd1;
                    if (c == 7'h2E) m_offs = m_offs - 8'd1;
                    memx(e, m_bp + {8'h00, m_offs}, wv, b, w, p);
                end
                7'h3E: m_offs = b;
                7'h5E: m_gr = wv;
                7'h6E: m_gr[7:0] = b;
                7'h7E: m_bp = wv;
                default: ;
            endcase
        end
        q.push_back(e);
        mv_dst = c; mv_src = s; mv_src_wide = w; mv_valid = 1'b1;
        @(negedge clk);
        mv_valid = 1'b0;
    endtask

    task automatic chk_state(input string tag);
        chk({tag, " ap"},   {12'h000, obs_ap}, {12'h000, m_ap});
        chk({tag, " sp"},   obs_sp, m_sp);
        chk({tag, " bp"},   obs_bp, m_bp);
        chk({tag, " offs"}, {8'h00, obs_offs}, {8'h00, m_offs});
        chk({tag, " dp0"},  obs_dp0, m_dp[0]);
        chk({tag, " dp1"},  obs_dp1, m_dp[1]);
        chk({tag, " gr"},   obs_gr, m_gr);
        chk({tag, " lc0"},  obs_lc0, m_lc[0]);
        chk({tag, " lc1"},  obs_lc1, m_lc[1]);
        chk({tag, " pfx"},  {15'h0, pfx_active}, {15'h0, m_pf});
        for (int i = 0; i < 16; i++) begin
            acc_rd_idx = 4'(i);
            #0.2;
            chk($sformatf("%s acc%0d", tag, i), acc_rd_data, m_acc[i]);
        end
        @(negedge clk);
    endtask

    // monitor: pops one expected item per presented move
    always @(posedge clk) begin
        if (!rst && mv_valid) begin
            #1;
            if (q.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL R10: actual unexpected move expected empty queue");
            end else begin
                got = q.pop_front();
                chk({got.tag, " mem_we"}, {15'h0, mem_we}, {15'h0, got.we});
                if (got.we) begin
                    chk({got.tag, " mem_word"}, {15'h0, mem_word}, {15'h0, got.word});
                    chk({got.tag, " mem_addr"}, mem_addr, got.addr);
                    chk({got.tag, " mem_wdata"}, mem_wdata, got.data);
                end
            end
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) m_acc[i] = '0;
        m_ap = '0; m_sp = '0; m_bp = '0; m_gr = '0; m_offs = '0; m_pfb = '0; m_pf = 1'b0;
        m_dp[0] = '0; m_dp[1] = '0; m_lc[0] = '0; m_lc[1] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R11 reset mem_we", {15'h0, mem_we}, 16'h0);
        chk_state("R11 reset");

        // accumulators, widths, widening
        mv(7'h29, 16'h1234, 1'b1, "R1 acc2 word");
        mv(7'h39, 16'hFFAB, 1'b0, "R2 acc3 byte zero-ext");
        mv(7'h0B, 16'h005A, 1'b0, "R9 prefix load");
        chk("R9 prefix active", {15'h0, pfx_active}, 16'h1);
        mv(7'h39, 16'h0077, 1'b0, "R4 prefixed acc11 R2");
        chk("R9 prefix cleared", {15'h0, pfx_active}, 16'h0);
        mv(7'h08, 16'hFF0B, 1'b1, "R4 R1 ap low bits");
        mv(7'h0A, 16'hBEEF, 1'b1, "R4 active acc");
        chk_state("R4 R2 accumulators");

        // null and unused codes
        mv(7'h76, 16'hFFFF, 1'b1, "R3 null");
        mv(7'h2D, 16'hFFFF, 1'b1, "R3 unused 010_1101");
        mv(7'h4E, 16'hFFFF, 1'b1, "R3 unused 100_1110");
        mv(7'h13, 16'hFFFF, 1'b1, "R3 unused 001_0011");
        chk_state("R3 null leaves state");

        // stack, loop counters
        mv(7'h1D, 16'h00FF, 1'b1, "R5 sp load");
        mv(7'h0D, 16'hAA12, 1'b0, "R5 push byte zero-ext");
        mv(7'h0D, 16'h1111, 1'b1, "R5 push back-to-back 1");
        mv(7'h0D, 16'h2222, 1'b1, "R5 push back-to-back 2");
        mv(7'h7B, 16'h00C1, 1'b0, "R9 prefix index ignored");
        mv(7'h0D, 16'h0034, 1'b0, "R5 R2 push prefix-extended");
        mv(7'h1D, 16'hFFFF, 1'b1, "R5 sp load top");
        mv(7'h0D, 16'h4321, 1'b1, "R5 push wraps");
        mv(7'h7D, 16'h4444, 1'b1, "R5 lc1");
        mv(7'h6D, 16'h0055, 1'b0, "R5 R2 lc0");
        chk_state("R5 stack and counters");

        // general register
        mv(7'h5E, 16'hABCD, 1'b1, "R8 gr");
        mv(7'h6E, 16'h1234, 1'b1, "R8 R1 grl low byte");
        mv(7'h0B, 16'h0099, 1'b0, "R9 prefix");
        mv(7'h1E, 16'h0099, 1'b0, "R8 grh prefixed");
        mv(7'h0B, 16'h0001, 1'b0, "R9 prefix");
        mv(7'h08, 16'h0007, 1'b0, "R8 prefixed 1000 null");
        chk_state("R8 general register");

        // base + offset
        mv(7'h7E, 16'h2000, 1'b1, "R7 bp");
        mv(7'h3E, 16'h12FF, 1'b1, "R7 R1 offs");
        mv(7'h1E, 16'h0055, 1'b0, "R7 pre-inc wraps offs");
        mv(7'h2E, 16'h0066, 1'b0, "R7 pre-dec wraps offs");
        mv(7'h0E, 16'h7788, 1'b1, "R7 no step word");
        mv(7'h1E, 16'h0001, 1'b1, "R7 back-to-back inc 1");
        mv(7'h1E, 16'h0002, 1'b1, "R7 back-to-back inc 2");
        chk_state("R7 frame");

        // data pointers
        mv(7'h3F, 16'h0000, 1'b1, "R6 dp0 load");
        mv(7'h7F, 16'h3000, 1'b1, "R6 dp1 load");
        mv(7'h2F, 16'h00A5, 1'b0, "R6 R10 dp0 pre-dec wraps byte");
        mv(7'h0F, 16'hC3C3, 1'b1, "R6 dp0 no step");
        mv(7'h5F, 16'h0011, 1'b0, "R6 R10 dp1 pre-inc");
        mv(7'h5F, 16'h0022, 1'b0, "R6 dp1 back-to-back inc");
        mv(7'h0B, 16'h00EE, 1'b0, "R9 prefix");
        mv(7'h6F, 16'h0033, 1'b0, "R6 R10 dp1 pre-dec prefixed word");
        mv(7'h4F, 16'h9999, 1'b1, "R6 dp1 no step");
        chk_state("R6 pointers");

        repeat (2) @(negedge clk);
        chk("R10 queue drained", 16'(q.size()), 16'h0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule